// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block derives all per-frame timing for a set of time-multiplexed serial streams from a fast master clock that runs at sixteen times the 1.024 MHz base. An 11-bit frame counter advances once per fast-clock cycle and covers one 8 kHz frame in 2048 cycles. An external active-low frame pulse keeps the counter aligned. The pulse is qualified only on a falling edge of a 4.096 MHz companion clock, which runs in phase with the fast clock and is sampled as a level in the fast-clock domain.

A delay select decides when the counter restarts. It either restarts at the qualifying edge itself, or one fast-clock cycle after it. From the count the block decodes a bit index, a channel index, and strobes that mark the first cycle of each bit and of each channel. A rate select picks the decoding: 8 fast cycles per bit, giving 256 bits in 32 channels, or 4 fast cycles per bit, giving 512 bits in 64 channels. For a downstream connection memory the block also issues an early one-cycle frame marker ahead of the boundary. The lead of that marker depends on the delay select.

A frame pulse that does not coincide with the natural end of the frame still realigns the counter, and the block raises a one-cycle sync-error flag when it does so.

Top module: `tdm_frame_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `frame_cnt` to 0, sets `cm_fp_n` to 1 and clears `sync_err` to 0.
- R2: Without a realignment, `frame_cnt` increases by exactly one per clock edge.
- R3: Without a realignment, `frame_cnt` wraps from 2047 to 0.
- R4: A frame boundary is detected at a clock edge where `clk4` was 1 at the previous edge, `clk4` is 0 now, and `fp_n` is 0. If `fp_n` is low at any other edge, the count is unaffected.
- R5: With `dly_sel`=0, `frame_cnt` reads 0 right after the boundary edge. With `dly_sel`=1, it reads 0 one edge later, and the count advances normally at the boundary edge itself.
- R6: With `rate_sel`=0, `bit_idx` = `frame_cnt`/8 (0..255). With `rate_sel`=1, `bit_idx` = `frame_cnt`/4 (0..511). In both cases `chan_idx` = `bit_idx`/8.
- R7: `bit_strobe` is 1 exactly when `frame_cnt` is a multiple of the bit length (8 or 4 cycles). `chan_strobe` is 1 exactly when `frame_cnt` is a multiple of eight bit lengths.
- R8: `cm_fp_n` is 0 for exactly one cycle per frame. With `dly_sel`=0 that cycle is `frame_cnt`=1977, which is 71 cycles before the count returns to 0. With `dly_sel`=1 it is `frame_cnt`=1979, which is 68 cycles before the boundary edge.
- R9: `sync_err` is 1 for one cycle, the first cycle in which `frame_cnt` reads 0 after a realignment, whenever the count just before that realignment was not 2047. A realignment that lands on the natural wrap raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| clk4 | input | 1 | 4.096 MHz companion clock, phase-locked to `clk` |
| fp_n | input | 1 | Active-low external frame pulse |
| rate_sel | input | 1 | 0: 2.048 Mbit/s slots, 1: 4.096 Mbit/s slots |
| dly_sel | input | 1 | 0: restart at boundary, 1: restart one cycle later |
| frame_cnt | output | 11 | Master frame counter |
| bit_idx | output | 9 | Bit slot index within the frame |
| chan_idx | output | 6 | Channel index within the frame |
| bit_strobe | output | 1 | First cycle of a bit slot |
| chan_strobe | output | 1 | First cycle of a channel |
| cm_fp_n | output | 1 | Early active-low frame marker for a connection memory |
| sync_err | output | 1 | One-cycle flag on an off-phase realignment |

## Verification
The hardest case to reach is a correctly timed frame pulse in delayed mode. Here the qualifying edge falls one cycle before the counter wraps, and it must still raise no sync error. The bench reaches it by recording the edge index of the previous accepted pulse and firing the next pulse on the companion-clock falling edge exactly a whole number of frames later. It contrasts this with a pulse placed a non-multiple of 2048 edges away and with a low pulse that straddles no falling edge. A full frame sweep under each rate and delay combination then confirms the counter, the slot decode and the early marker against arithmetic expectations.

// File: rtl/tft_pkg.sv
`timescale 1ns/1ps
package tft_pkg;
    localparam int FRAME_LEN_DEF     = 2048;
    localparam int LEAD_NODLY_DEF    = 71;
    localparam int LEAD_DLY_DEF      = 68;
    localparam int SLOW_SHIFT_DEF    = 3;
    localparam int FAST_SHIFT_DEF    = 2;
    localparam int BITS_PER_CHAN_DEF = 8;

    typedef enum logic {
        RATE_2M = 1'b0,
        RATE_4M = 1'b1
    } rate_e;

    typedef enum logic {
        ALIGN_AT_EDGE = 1'b0,
        ALIGN_LATE    = 1'b1
    } align_mode_e;

    typedef struct packed {
        logic hit;
        logic load;
    } align_evt_t;

    // Count at which the early connection-memory marker fires.
    function automatic int cm_mark(int frame_len, int lead, logic late);
        return late ? (frame_len - lead - 1) : (frame_len - lead);
    endfunction
endpackage

// File: rtl/tft_align.sv
`timescale 1ns/1ps
module tft_align
    import tft_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clk4,
    input  logic        fp_n,
    input  align_mode_e mode,
    output align_evt_t  evt
);
    logic clk4_q;
    logic pend_q;
    logic hit;

    // Falling edge of the companion clock with the frame pulse low.
    assign hit = clk4_q & ~clk4 & ~fp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk4_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            clk4_q <= clk4;
            pend_q <= hit && (mode == ALIGN_LATE);
        end
    end

    always_comb begin
        evt.hit  = hit;
        evt.load = (mode == ALIGN_LATE) ? pend_q : hit;
    end
endmodule

// File: rtl/tft_counter.sv
`timescale 1ns/1ps
module tft_counter #(
    parameter int FRAME_LEN = 2048,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next,
    output logic             sync_err
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    always_comb begin
        if (load || cnt == LAST) cnt_next = '0;
        else                     cnt_next = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            sync_err <= 1'b0;
        end else begin
            cnt      <= cnt_next;
            sync_err <= load && (cnt != LAST);
        end
    end
endmodule

// File: rtl/tft_slots.sv
`timescale 1ns/1ps
module tft_slots
    import tft_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int SLOW_SH = 3,
    parameter int FAST_SH = 2,
    parameter int CH_SH   = 3,
    parameter int BIT_W   = CNT_W - FAST_SH,
    parameter int CHAN_W  = BIT_W - CH_SH
) (
    input  logic [CNT_W-1:0]  cnt,
    input  rate_e             rate,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [CHAN_W-1:0] chan_idx,
    output logic              bit_stb,
    output logic              chan_stb
);
    localparam logic [CNT_W-1:0] FAST_BIT_MASK  = CNT_W'((1 << FAST_SH) - 1);
    localparam logic [CNT_W-1:0] SLOW_BIT_MASK  = CNT_W'((1 << SLOW_SH) - 1);
    localparam logic [CNT_W-1:0] FAST_CHAN_MASK = CNT_W'((1 << (FAST_SH + CH_SH)) - 1);
    localparam logic [CNT_W-1:0] SLOW_CHAN_MASK = CNT_W'((1 << (SLOW_SH + CH_SH)) - 1);

    always_comb begin
        if (rate == RATE_4M) begin
            bit_idx  = BIT_W'(cnt >> FAST_SH);
            bit_stb  = (cnt & FAST_BIT_MASK) == '0;
            chan_stb = (cnt & FAST_CHAN_MASK) == '0;
        end else begin
            bit_idx  = BIT_W'(cnt >> SLOW_SH);
            bit_stb  = (cnt & SLOW_BIT_MASK) == '0;
            chan_stb = (cnt & SLOW_CHAN_MASK) == '0;
        end
        chan_idx = CHAN_W'(bit_idx >> CH_SH);
    end
endmodule

// File: rtl/tft_cm_pulse.sv
`timescale 1ns/1ps
module tft_cm_pulse
    import tft_pkg::*;
#(
    parameter int FRAME_LEN  = 2048,
    parameter int CNT_W      = $clog2(FRAME_LEN),
    parameter int LEAD_NODLY = 71,
    parameter int LEAD_DLY   = 68
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_next,
    input  align_mode_e      mode,
    output logic             cm_n
);
    localparam logic [CNT_W-1:0] MARK_EDGE = CNT_W'(cm_mark(FRAME_LEN, LEAD_NODLY, 1'b0));
    localparam logic [CNT_W-1:0] MARK_LATE = CNT_W'(cm_mark(FRAME_LEN, LEAD_DLY, 1'b1));

    logic [CNT_W-1:0] mark;
    assign mark = (mode == ALIGN_LATE) ? MARK_LATE : MARK_EDGE;

    always_ff @(posedge clk) begin
        if (rst) cm_n <= 1'b1;
        else     cm_n <= (cnt_next != mark);
    end
endmodule

// File: rtl/tdm_frame_timer.sv
`timescale 1ns/1ps
module tdm_frame_timer
    import tft_pkg::*;
#(
    parameter int FRAME_LEN     = FRAME_LEN_DEF,
    parameter int LEAD_NODLY    = LEAD_NODLY_DEF,
    parameter int LEAD_DLY      = LEAD_DLY_DEF,
    parameter int SLOW_SHIFT    = SLOW_SHIFT_DEF,
    parameter int FAST_SHIFT    = FAST_SHIFT_DEF,
    parameter int BITS_PER_CHAN = BITS_PER_CHAN_DEF,
    localparam int CNT_W  = $clog2(FRAME_LEN),
    localparam int CH_SH  = $clog2(BITS_PER_CHAN),
    localparam int BIT_W  = CNT_W - FAST_SHIFT,
    localparam int CHAN_W = BIT_W - CH_SH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk4,
    input  logic              fp_n,
    input  logic              rate_sel,
    input  logic              dly_sel,
    output logic [CNT_W-1:0]  frame_cnt,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [CHAN_W-1:0] chan_idx,
    output logic              bit_strobe,
    output logic              chan_strobe,
    output logic              cm_fp_n,
    output logic              sync_err
);
    align_mode_e      mode;
    rate_e            rate;
    align_evt_t       evt;
    logic             fp_hit;
    logic             align_load;
    logic [CNT_W-1:0] cnt_next;

    assign mode       = align_mode_e'(dly_sel);
    assign rate       = rate_e'(rate_sel);
    assign fp_hit     = evt.hit;
    assign align_load = evt.load;

    tft_align u_align (
        .clk  (clk),
        .rst  (rst),
        .clk4 (clk4),
        .fp_n (fp_n),
        .mode (mode),
        .evt  (evt)
    );

    tft_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (align_load),
        .cnt      (frame_cnt),
        .cnt_next (cnt_next),
        .sync_err (sync_err)
    );

    tft_slots #(
        .CNT_W(CNT_W), .SLOW_SH(SLOW_SHIFT), .FAST_SH(FAST_SHIFT),
        .CH_SH(CH_SH), .BIT_W(BIT_W), .CHAN_W(CHAN_W)
    ) u_slots (
        .cnt      (frame_cnt),
        .rate     (rate),
        .bit_idx  (bit_idx),
        .chan_idx (chan_idx),
        .bit_stb  (bit_strobe),
        .chan_stb (chan_strobe)
    );

    tft_cm_pulse #(
        .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W),
        .LEAD_NODLY(LEAD_NODLY), .LEAD_DLY(LEAD_DLY)
    ) u_cm (
        .clk      (clk),
        .rst      (rst),
        .cnt_next (cnt_next),
        .mode     (mode),
        .cm_n     (cm_fp_n)
    );
endmodule

// File: rtl/tft_checker.sv
`timescale 1ns/1ps
module tft_checker #(
    parameter int FRAME_LEN = 2048,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input logic             clk,
    input logic             rst,
    input logic             dly_sel,
    input logic             fp_hit,
    input logic             align_load,
    input logic [CNT_W-1:0] frame_cnt,
    input logic             bit_strobe,
    input logic             chan_strobe,
    input logic             cm_fp_n,
    input logic             sync_err
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!align_load && frame_cnt != LAST) |=> frame_cnt == $past(frame_cnt) + 1'b1);

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (!align_load && frame_cnt == LAST) |=> frame_cnt == '0);

    p_edge_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (!dly_sel && fp_hit) |=> frame_cnt == '0);

    p_late_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (dly_sel && fp_hit) |=> align_load);

    p_load_zero_r5: assert property (@(posedge clk) disable iff (rst)
        align_load |=> frame_cnt == '0);

    p_strobe_nest_r7: assert property (@(posedge clk) disable iff (rst)
        chan_strobe |-> bit_strobe);

    p_cm_single_r8: assert property (@(posedge clk) disable iff (rst)
        !cm_fp_n |=> cm_fp_n);

    p_err_at_zero_r9: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> frame_cnt == '0);

    p_err_single_r9: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);
endmodule

bind tdm_frame_timer tft_checker #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dly_sel     (dly_sel),
    .fp_hit      (fp_hit),
    .align_load  (align_load),
    .frame_cnt   (frame_cnt),
    .bit_strobe  (bit_strobe),
    .chan_strobe (chan_strobe),
    .cm_fp_n     (cm_fp_n),
    .sync_err    (sync_err)
);

// File: tb/sim_tdm_frame_timer.sv
`timescale 1ns/1ps
module sim_tdm_frame_timer;
    localparam int FRAME = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk4 = 1'b1;
    logic        fp_n = 1'b1;
    logic        rate_sel = 1'b0;
    logic        dly_sel = 1'b0;
    logic [10:0] frame_cnt;
    logic [8:0]  bit_idx;
    logic [5:0]  chan_idx;
    logic        bit_strobe;
    logic        chan_strobe;
    logic        cm_fp_n;
    logic        sync_err;

    int vec = 0;
    int err = 0;
    int m = 0;          // posedges seen
    int anchor = 0;     // edge after which the count reads 0
    int fp_at = -1;     // edge where a real pulse is presented
    int bad_at = -1;    // edge where a non-qualifying low pulse is presented
    int pend_a = -1;    // edge where the count is expected to restart
    int last_e = 0;
    int fall_ref = 0;   // a known companion-clock falling edge
    int ph = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tdm_frame_timer u0 (
        .clk(clk), .rst(rst), .clk4(clk4), .fp_n(fp_n),
        .rate_sel(rate_sel), .dly_sel(dly_sel),
        .frame_cnt(frame_cnt), .bit_idx(bit_idx), .chan_idx(chan_idx),
        .bit_strobe(bit_strobe), .chan_strobe(chan_strobe),
        .cm_fp_n(cm_fp_n), .sync_err(sync_err)
    );

    task automatic chk(string req, int act, int exp);
        vec++;
        if (act != exp) begin
            err++;
            $display("FAIL %s edge=%0d act=%0d exp=%0d rate=%0d dly=%0d",
                     req, m, act, exp, rate_sel, dly_sel);
        end
    endtask

    task automatic check_all(bit loaded, bit exp_err);
        int c, sh, mark;
        string tag;
        c    = (m - anchor) % FRAME;
        sh   = rate_sel ? 2 : 3;
        mark = dly_sel ? (FRAME - 68 - 1) : (FRAME - 71);
        if (loaded)            tag = "R5";
        else if (m == bad_at)  tag = "R4";
        else if (c == 0)       tag = "R3";
        else                   tag = "R2";
        chk(tag,  int'(frame_cnt),   c);
        chk("R6", int'(bit_idx),     c >> sh);
        chk("R6", int'(chan_idx),    (c >> sh) >> 3);
        chk("R7", int'(bit_strobe),  int'((c % (1 << sh)) == 0));
        chk("R7", int'(chan_strobe), int'((c % (8 << sh)) == 0));
        chk("R8", int'(cm_fp_n),     int'(c != mark));
        chk("R9", int'(sync_err),    int'(exp_err));
    endtask

    task automatic tick();
        bit loaded, exp_err;
        @(posedge clk);
        m++;
        @(negedge clk);
        loaded  = 1'b0;
        exp_err = 1'b0;
        if (rst) begin
            anchor = m;
        end else begin
            if (m == pend_a) begin
                loaded  = 1'b1;
                exp_err = ((m - 1 - anchor) % FRAME) != (FRAME - 1);
                anchor  = m;
            end
            check_all(loaded, exp_err);
        end
        // drive for the next edge
        ph   = (ph + 1) % 4;
        clk4 = (ph < 2);
        if (ph == 2) fall_ref = m + 1;
        fp_n = !((m + 1) == fp_at || (m + 1) == bad_at);
    endtask

    task automatic run_cfg(logic r, logic d);
        rate_sel = r;
        dly_sel  = d;
        fp_at = -1; bad_at = -1; pend_a = -1;
        rst = 1'b1;
        repeat (4) tick();
        chk("R1", int'(frame_cnt), 0);
        chk("R1", int'(cm_fp_n), 1);
        chk("R1", int'(sync_err), 0);
        rst = 1'b0;
        repeat (40) tick();
        // first alignment, generally off-phase
        fp_at  = fall_ref + 16;
        pend_a = fp_at + int'(d);
        last_e = fp_at;
        repeat (2300) tick();
        // pulse a whole number of frames after the previous one
        fp_at  = last_e + FRAME * (((m + 8 - last_e) / FRAME) + 1);
        pend_a = fp_at + int'(d);
        last_e = fp_at;
        while (m < pend_a + 2) tick();
        // low pulse that straddles no falling edge
        bad_at = fall_ref + 41;
        while (m < bad_at + 50) tick();
        // off-phase pulse
        fp_at  = fall_ref + 148;
        pend_a = fp_at + int'(d);
        last_e = fp_at;
        repeat (2100) tick();
    endtask

    initial begin
        run_cfg(1'b0, 1'b0);
        run_cfg(1'b1, 1'b0);
        run_cfg(1'b0, 1'b1);
        run_cfg(1'b1, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            err++;
            $display("FAIL watchdog (all requirements) act=%0d exp=%0d", m, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    end
endmodule